// File: doc/BRIEF.md
# Cable Drop Compensation Controller

This block sits behind a power sink's output switch. Once the switch is on, it looks at samples of the output voltage and compares each one with a trip level taken from the selected target. When the output is below that level, it raises the voltage it asks the source for. How it raises the request depends on the kind of offer in use. For a fixed offer it moves to the next higher fixed offer in the source's list. For a programmable offer it adds a small step to the request. It keeps doing this until the output recovers or a limit stops it. The result is reported as a pass, which keeps normal charging, or as a low-voltage failure.

Every voltage is an unsigned integer in units of 10 mV. The target is picked by a 3-bit code. Codes 0 to 3 select 5, 9, 15 and 20 V. Codes 4 to 7, where bit 2 is set, select the battery-oriented targets of 4.3, 8.6, 12.9 and 17.2 V. Compensation never runs for the battery-oriented targets.

The source's offer list comes in on a flat bus with one valid bit per slot. The slots can be in any order. The list must be held stable while a run is in progress.

Output samples arrive on a valid/ready stream. `vout_ready` is high only while the block is waiting for a sample. The producer must keep `vout_valid` and `vout_data` steady until a cycle in which both valid and ready are high. A sample offered at any other time is not consumed, and no sample is ever dropped.

Each new request is announced by a one-cycle `req_strobe`, with the new value on `req_volts`. After that strobe, `vout_ready` stays low for `SETTLE_CYC` cycles so the source and the cable can settle before the next sample is taken.

Top module: `vdrop_comp`

## Requirements
- R1: After reset, `vout_ready`, `req_strobe`, `busy`, `comp_ok` and `low_volt` are 0 and `req_volts` is 0.
- R2: A `start` pulse accepted while idle or done loads `req_volts` with `base_req`. For codes 0, 1, 2 and 3, the trip levels are 470, 846, 1410 and 1880. A sample at or above the trip level ends the run with `comp_ok` and no strobe. A sample one unit below the trip level causes a request.
- R3: When code bit 2 is 1, a run ends with `comp_ok` and never raises `vout_ready` or `req_strobe`.
- R4: With `offer_pps` = 1, each low sample raises `req_volts` by 10 (0.1 V) and pulses `req_strobe`.
- R5: In programmable mode the total added to `base_req` never exceeds 130. With base 500 and a fixed drop of 100, the run ends passing at 570. If the next step would pass the cap, a low sample ends the run with `low_volt` and no strobe.
- R6: With `offer_pps` = 0, a low sample requests the smallest valid offer strictly above the current request, whatever its slot. Slot i is bits [12i+11:12i], and valid bit i enables it.
- R7: In fixed mode, a low sample ends the run with `low_volt` and no strobe in two cases: no valid higher offer exists, or the chosen offer lies more than 400 above `base_req`.
- R8: After each strobe, `vout_ready` stays low for exactly `SETTLE_CYC` (8) cycles. A sample held valid during that time is taken only once ready returns.
- R9: At most one of `busy`, `comp_ok` and `low_volt` is high at any time. A new `start` from either done state begins a fresh run.
- R10: `req_strobe` lasts a single cycle, and `req_volts` changes only on a strobe or an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run (output switch just enabled) |
| tgt_code | input | 3 | Target select code |
| offer_pps | input | 1 | 1 = programmable offer, 0 = fixed offer |
| base_req | input | VW | Request voltage agreed before compensation |
| offer_volts | input | N_OFFERS*VW | Fixed offer voltages, one slot per offer |
| offer_valid | input | N_OFFERS | Slot enables |
| vout_valid | input | 1 | Output sample valid |
| vout_ready | output | 1 | Block accepts a sample |
| vout_data | input | VW | Output voltage sample |
| req_strobe | output | 1 | One-cycle pulse marking a new request |
| req_volts | output | VW | Current request voltage |
| busy | output | 1 | Run in progress |
| comp_ok | output | 1 | Run ended with the output at or above trip |
| low_volt | output | 1 | Run ended with compensation exhausted |

## Verification
The programmable cap is the hardest case to reach. Hitting it takes thirteen full request-and-settle rounds, and every round must answer with a sample that is still too low. The stimulus models the cable as a constant drop larger than the cap. Each reply is the latest request minus that drop, so the bench walks the whole ladder up to 630 and then sees the refusal. A second hard case is a sample that the producer presents during settling: the bench holds it valid from the strobe cycle onward and counts the cycles until it is taken.

// File: rtl/vdrop_pkg.sv
package vdrop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SAMPLE,
    ST_SETTLE,
    ST_PASS,
    ST_LOW
  } comp_state_e;

  // Target voltage in 10 mV units for each select code.
  function automatic int unsigned target_cv(input logic [2:0] code);
    int unsigned t;
    case (code)
      3'd0:    t = 500;
      3'd1:    t = 900;
      3'd2:    t = 1500;
      3'd3:    t = 2000;
      3'd4:    t = 430;
      3'd5:    t = 860;
      3'd6:    t = 1290;
      default: t = 1720;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/vdrop_trip_dec.sv
module vdrop_trip_dec #(
  parameter int          VW       = 12,
  parameter int unsigned TRIP_PCT = 94
) (
  input  logic [2:0]    code,
  output logic [VW-1:0] trip,
  output logic          comp_en
);
  import vdrop_pkg::*;

  always_comb begin
    trip    = VW'((target_cv(code) * TRIP_PCT) / 100);
    comp_en = ~code[2];
  end

endmodule

// File: rtl/vdrop_offer_pick.sv
module vdrop_offer_pick #(
  parameter int VW       = 12,
  parameter int N_OFFERS = 6
) (
  input  logic [N_OFFERS*VW-1:0] offer_volts,
  input  logic [N_OFFERS-1:0]    offer_valid,
  input  logic [VW-1:0]          floor_v,
  output logic                   found,
  output logic [VW-1:0]          next_v
);
  logic [VW-1:0] slot_v [N_OFFERS];

  for (genvar g = 0; g < N_OFFERS; g++) begin : g_slot
    assign slot_v[g] = offer_volts[g*VW +: VW];
  end

  // Smallest valid offer strictly above floor_v, slot order irrelevant.
  always_comb begin
    found  = 1'b0;
    next_v = '0;
    for (int i = 0; i < N_OFFERS; i++) begin
      if (offer_valid[i] && (slot_v[i] > floor_v) &&
          (!found || (slot_v[i] < next_v))) begin
        found  = 1'b1;
        next_v = slot_v[i];
      end
    end
  end

endmodule

// File: rtl/vdrop_settle.sv
module vdrop_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(SETTLE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired = (cnt_q == CW'(1));

endmodule

// File: rtl/vdrop_comp.sv
module vdrop_comp #(
  parameter int          VW         = 12,
  parameter int          N_OFFERS   = 6,
  parameter int          SETTLE_CYC = 8,
  parameter int          PPS_STEP   = 10,
  parameter int          PPS_LIMIT  = 130,
  parameter int          FIX_LIMIT  = 400,
  parameter int unsigned TRIP_PCT   = 94
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2:0]             tgt_code,
  input  logic                   offer_pps,
  input  logic [VW-1:0]          base_req,
  input  logic [N_OFFERS*VW-1:0] offer_volts,
  input  logic [N_OFFERS-1:0]    offer_valid,
  input  logic                   vout_valid,
  output logic                   vout_ready,
  input  logic [VW-1:0]          vout_data,
  output logic                   req_strobe,
  output logic [VW-1:0]          req_volts,
  output logic                   busy,
  output logic                   comp_ok,
  output logic                   low_volt
);
  import vdrop_pkg::*;

  localparam int VW1 = VW + 1;

  comp_state_e   state_q, state_d;
  logic [VW-1:0] req_q, base_q, added_q, step_v;
  logic          pps_q, strobe_q, step_go;
  logic [2:0]    code_q;

  logic [VW-1:0] trip_lvl;
  logic          comp_en;
  logic          pick_found;
  logic [VW-1:0] pick_v;
  logic          settle_done;

  logic start_acc, accept, is_low, pps_room, fix_room;

  // Trip level comes from the registered code: one cycle of arming
  // keeps the multiply off the start path.
  vdrop_trip_dec #(.VW(VW), .TRIP_PCT(TRIP_PCT)) u_trip (
    .code    (code_q),
    .trip    (trip_lvl),
    .comp_en (comp_en)
  );

  vdrop_offer_pick #(.VW(VW), .N_OFFERS(N_OFFERS)) u_pick (
    .offer_volts (offer_volts),
    .offer_valid (offer_valid),
    .floor_v     (req_q),
    .found       (pick_found),
    .next_v      (pick_v)
  );

  vdrop_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (step_go),
    .expired (settle_done)
  );

  always_comb begin
    start_acc = start && ((state_q == ST_IDLE) || (state_q == ST_PASS) ||
                          (state_q == ST_LOW));
    accept    = vout_valid && (state_q == ST_SAMPLE);
    is_low    = (vout_data < trip_lvl);
    pps_room  = ({1'b0, added_q} + VW1'(PPS_STEP)) <= VW1'(PPS_LIMIT);
    fix_room  = pick_found &&
                ({1'b0, pick_v} <= ({1'b0, base_q} + VW1'(FIX_LIMIT)));
  end

  always_comb begin
    state_d = state_q;
    step_go = 1'b0;
    step_v  = req_q;
    case (state_q)
      ST_IDLE, ST_PASS, ST_LOW: begin
        if (start) state_d = ST_ARM;
      end
      ST_ARM: begin
        state_d = comp_en ? ST_SAMPLE : ST_PASS;
      end
      ST_SAMPLE: begin
        if (accept) begin
          if (!is_low) begin
            state_d = ST_PASS;
          end else if (pps_q && pps_room) begin
            step_go = 1'b1;
            step_v  = req_q + VW'(PPS_STEP);
            state_d = ST_SETTLE;
          end else if (!pps_q && fix_room) begin
            step_go = 1'b1;
            step_v  = pick_v;
            state_d = ST_SETTLE;
          end else begin
            state_d = ST_LOW;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_done) state_d = ST_SAMPLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= 1'b0;
      req_q    <= '0;
      base_q   <= '0;
      added_q  <= '0;
      pps_q    <= 1'b0;
      code_q   <= '0;
    end else begin
      state_q  <= state_d;
      strobe_q <= step_go;
      if (start_acc) begin
        req_q   <= base_req;
        base_q  <= base_req;
        added_q <= '0;
        pps_q   <= offer_pps;
        code_q  <= tgt_code;
      end else if (step_go) begin
        req_q <= step_v;
        if (pps_q) added_q <= added_q + VW'(PPS_STEP);
      end
    end
  end

  assign vout_ready = (state_q == ST_SAMPLE);
  assign req_strobe = strobe_q;
  assign req_volts  = req_q;
  assign busy       = (state_q == ST_ARM) || (state_q == ST_SAMPLE) ||
                      (state_q == ST_SETTLE);
  assign comp_ok    = (state_q == ST_PASS);
  assign low_volt   = (state_q == ST_LOW);

endmodule

// File: rtl/vdrop_comp_chk.sv
module vdrop_comp_chk #(
  parameter int VW        = 12,
  parameter int PPS_STEP  = 10,
  parameter int PPS_LIMIT = 130,
  parameter int FIX_LIMIT = 400
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          vout_ready,
  input logic          req_strobe,
  input logic [VW-1:0] req_volts,
  input logic          busy,
  input logic          comp_ok,
  input logic          low_volt,
  input logic          pps_q,
  input logic          code2,
  input logic [VW-1:0] base_q
);
  localparam int VW1 = VW + 1;

  // R9
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, comp_ok, low_volt}));

  // R8
  settle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> !vout_ready);

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |=> !req_strobe);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_strobe && !$past(start)) |-> $stable(req_volts));

  // R4
  pps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && pps_q) |-> ((req_volts - $past(req_volts)) == VW'(PPS_STEP)));

  // R5
  pps_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && pps_q) |-> ({1'b0, req_volts} <= ({1'b0, base_q} + VW1'(PPS_LIMIT))));

  // R7
  fix_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && !pps_q) |->
      (({1'b0, req_volts} <= ({1'b0, base_q} + VW1'(FIX_LIMIT))) &&
       (req_volts > $past(req_volts))));

  // R3
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code2 |-> (!req_strobe && !vout_ready));

endmodule

bind vdrop_comp vdrop_comp_chk #(
  .VW(VW), .PPS_STEP(PPS_STEP), .PPS_LIMIT(PPS_LIMIT), .FIX_LIMIT(FIX_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .vout_ready (vout_ready),
  .req_strobe (req_strobe),
  .req_volts  (req_volts),
  .busy       (busy),
  .comp_ok    (comp_ok),
  .low_volt   (low_volt),
  .pps_q      (pps_q),
  .code2      (code_q[2]),
  .base_q     (base_q)
);

// File: tb/test_vdrop_comp.sv
module test_vdrop_comp;
  localparam int VW     = 12;
  localparam int NOFF   = 6;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] tgt_code = '0;
  logic offer_pps = 1'b0;
  logic [VW-1:0] base_req = '0;
  logic [NOFF*VW-1:0] offer_volts = '0;
  logic [NOFF-1:0] offer_valid = '0;
  logic vout_valid = 1'b0;
  logic [VW-1:0] vout_data = '0;
  logic vout_ready, req_strobe, busy, comp_ok, low_volt;
  logic [VW-1:0] req_volts;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vdrop_comp #(.VW(VW), .N_OFFERS(NOFF), .SETTLE_CYC(SETTLE)) i_vdrop_comp (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_code(tgt_code),
    .offer_pps(offer_pps), .base_req(base_req), .offer_volts(offer_volts),
    .offer_valid(offer_valid), .vout_valid(vout_valid), .vout_ready(vout_ready),
    .vout_data(vout_data), .req_strobe(req_strobe), .req_volts(req_volts),
    .busy(busy), .comp_ok(comp_ok), .low_volt(low_volt)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input int code, input bit pps, input int base);
    @(negedge clk);
    tgt_code = 3'(code); offer_pps = pps; base_req = VW'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Present one sample, wait for its acceptance, report outputs one cycle on.
  task automatic send(input int v, output bit stb, output int rv);
    while (!vout_ready) @(negedge clk);
    vout_valid = 1'b1; vout_data = VW'(v);
    @(negedge clk);
    vout_valid = 1'b0;
    stb = req_strobe; rv = int'(req_volts);
  endtask

  task automatic t_reset();
    chk_eq("R1 ready", vout_ready, 0);
    chk_eq("R1 strobe", req_strobe, 0);
    chk_eq("R1 status", {busy, comp_ok, low_volt}, 0);
    chk_eq("R1 req", req_volts, 0);
  endtask

  task automatic t_trip();
    int tgt[4] = '{500, 900, 1500, 2000};
    int trp[4] = '{470, 846, 1410, 1880};
    bit s; int r;
    for (int i = 0; i < 4; i++) begin
      do_start(i, 1'b1, tgt[i]);
      chk_eq("R2 req loaded", req_volts, tgt[i]);
      send(trp[i], s, r);
      chk_eq("R2 at trip no strobe", s, 0);
      chk_eq("R2 at trip pass", comp_ok, 1);
      do_start(i, 1'b1, tgt[i]);
      send(trp[i] - 1, s, r);
      chk_eq("R2 below trip strobe", s, 1);
      chk_eq("R2 below trip req", r, tgt[i] + 10);
      send(trp[i], s, r);
      chk_eq("R9 pass after step", {busy, comp_ok, low_volt}, 3'b010);
    end
  endtask

  task automatic t_disabled();
    do_start(5, 1'b1, 860);
    vout_valid = 1'b1; vout_data = VW'(100);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_eq("R3 ready low", vout_ready, 0);
      chk_eq("R3 no strobe", req_strobe, 0);
    end
    vout_valid = 1'b0;
    chk_eq("R3 pass", comp_ok, 1);
    chk_eq("R3 req unchanged", req_volts, 860);
  endtask

  task automatic t_pps_walk(input int drop, input int exp_n, input int exp_req,
                            input bit exp_pass);
    bit s; int r; int cur = 500; int n = 0;
    do_start(0, 1'b1, 500);
    for (int k = 0; k < 20; k++) begin
      send(cur - drop, s, r);
      if (!s) break;
      n++;
      chk_eq("R4 step of 10", r - cur, 10);
      cur = r;
      @(negedge clk);
      chk_eq("R10 strobe one cycle", req_strobe, 0);
      chk_eq("R10 req held", req_volts, cur);
    end
    chk_eq("R5 step count", n, exp_n);
    chk_eq("R5 final request", cur, exp_req);
    chk_eq("R5 pass flag", comp_ok, exp_pass);
    chk_eq("R5 low flag", low_volt, !exp_pass);
    chk_eq("R9 not busy", busy, 0);
  endtask

  task automatic t_fixed();
    bit s; int r;
    // slots: 0=2000 1=500 2=1500 3=900
    offer_volts = {12'd0, 12'd0, 12'd900, 12'd1500, 12'd500, 12'd2000};
    offer_valid = 6'b001111;
    do_start(0, 1'b0, 500);
    send(300, s, r);
    chk_eq("R6 strobe", s, 1);
    chk_eq("R6 next offer", r, 900);
    send(800, s, r);
    chk_eq("R6 pass", comp_ok, 1);
    do_start(0, 1'b0, 500);
    send(300, s, r);
    send(450, s, r);
    chk_eq("R7 over limit no strobe", s, 0);
    chk_eq("R7 over limit low", low_volt, 1);
    chk_eq("R7 req stays", r, 900);
    offer_valid = 6'b000111;
    do_start(0, 1'b0, 500);
    chk_eq("R9 restart busy", busy, 1);
    send(300, s, r);
    chk_eq("R7 masked slot no strobe", s, 0);
    chk_eq("R7 masked slot low", low_volt, 1);
    offer_valid = 6'b001010;
    do_start(1, 1'b0, 900);
    send(500, s, r);
    chk_eq("R7 none higher no strobe", s, 0);
    chk_eq("R7 none higher low", low_volt, 1);
  endtask

  task automatic t_settle();
    bit s; int r; int n = 0;
    do_start(1, 1'b1, 900);
    send(700, s, r);
    chk_eq("R8 strobe", s, 1);
    vout_valid = 1'b1; vout_data = VW'(900);
    while (!vout_ready && n < 40) begin
      if (n > 0) chk_eq("R8 no strobe while settling", req_strobe, 0);
      n++;
      @(negedge clk);
    end
    chk_eq("R8 settle length", n, SETTLE);
    chk_eq("R8 held sample not yet taken", busy, 1);
    @(negedge clk);
    vout_valid = 1'b0;
    chk_eq("R8 held sample taken", comp_ok, 1);
    chk_eq("R8 req", req_volts, 910);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trip();
    t_disabled();
    t_pps_walk(100, 7, 570, 1'b1);
    t_pps_walk(300, 13, 630, 1'b0);
    t_fixed();
    t_settle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule